// File: doc/BRIEF.md
# Parallel Code-Phase Correlator Bank

This block speeds up code acquisition in a direct-sequence receiver by testing several code-phase hypotheses at once. A local maximal-length sequence is held in a circular shift register. Each correlator reads a different tap of that register, so it sees the replica code delayed by its own whole number of chips. Every correlator multiplies the replica against the same received hard-decision chip stream, using bipolar arithmetic. Each one integrates over one full code period, then dumps its sum and holds it.

At the end of each period, a pipelined comparator tree picks the largest sum. The block reports the winning code phase and the winning value. The value lets a later stage apply its own minimum-level test against noise-only periods. When the bank has fewer correlators than the code has chips, the searched phase window moves forward by the bank width after each period, and one search takes several periods. A search begins with a start pulse. After that, each cycle with `chip_valid` high feeds one chip to the bank.

Top module: `pcorr_bank`

## Requirements
- R1: While reset is active and just after it is released, `busy` and `res_valid` are 0.
- R2: The replica is the sequence c[m+W] = c[m+FB] xor c[m], with c[0..W-1] = 1 and period N = 2^W-1. Hypothesis p pairs chip n of a period with c[(n-p) mod N]. A product is +1 when the received bit equals the replica bit and -1 when it differs, so bit 1 stands for +1 and bit 0 for -1.
- R3: Each reported sum covers exactly N accepted chips. Cycles with `chip_valid` low are skipped without affecting any sum.
- R4: Period g of a search tests phases g*M up to g*M+M-1, where M is the bank width. Phases N or above are excluded. A search runs ceil(N/M) periods and gives one result per period.
- R5: `res_phase` is the phase with the largest sum among those tested in the period. On equal sums the lowest phase wins.
- R6: `res_valid` is a one-cycle pulse. It is high in the cycle after clog2(M) further rising edges following the edge that samples the period's final chip. `res_peak` carries the winning sum in two's complement.
- R7: A start pulse while `busy` is high is ignored. Chips offered while idle are ignored.
- R8: `busy` goes high in the cycle after an accepted start. It goes low right after the edge that samples the last chip of the final period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (used only while idle) |
| chip_valid | input | 1 | A received chip is present this cycle |
| rx_chip | input | 1 | Received hard-decision chip, 1 stands for +1 |
| busy | output | 1 | A search is in progress |
| res_valid | output | 1 | Result pulse, once per period |
| res_phase | output | $clog2(N) | Winning code phase in chips |
| res_peak | output | $clog2(N+1)+1 | Winning correlation sum, signed |

## Verification
The bench builds two copies of the block side by side on one 31-chip code, one with 8 correlators and one with 31. The 8-wide copy runs four periods per search. Its last window is partly masked, and its result goes through a three-level tree. The 31-wide copy covers every phase in one period, through a five-level tree padded with an empty leaf. Both copies see the same aligned, noisy, stalled, constant and random chip streams. The constant stream makes every hypothesis tie, and one search aims at phase 30, the last phase of the final window.

// File: rtl/pcorr_pkg.sv
package pcorr_pkg;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } srch_e;

endpackage

// File: rtl/pcorr_codegen.sv
module pcorr_codegen #(
    parameter int W  = 5,
    parameter int FB = 2,
    parameter int N  = (1 << W) - 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         adv,
    output logic [N-1:0] taps
);

    // Ring tap i holds c[(n - i) mod N] at chip n of a period.
    function automatic logic [N-1:0] ring_init();
        logic [N-1:0] c;
        logic [N-1:0] r;
        c = '0;
        for (int m = 0; m < W; m++) c[m] = 1'b1;
        for (int m = W; m < N; m++) c[m] = c[m - W + FB] ^ c[m - W];
        for (int i = 0; i < N; i++) r[i] = c[(N - i) % N];
        return r;
    endfunction

    localparam logic [N-1:0] INIT = ring_init();
    localparam int ONES = (N + 1) / 2;

    typedef struct packed {
        logic [N-1:0] ring;
    } cg_t;

    cg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.ring = INIT;
        end else if (adv) begin
            s_d.ring = {s_q.ring[N-2:0], s_q.ring[N-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ring: INIT};
        else        s_q <= s_d;
    end

    assign taps = s_q.ring;

    // R2: rotation keeps the m-sequence weight of 2^(W-1) ones
    a_r2_ring_weight: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(s_q.ring) == ONES);

    // R2: one chip step moves the oldest tap to the front
    a_r2_ring_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> s_q.ring[0] == $past(s_q.ring[N-1]));

endmodule

// File: rtl/pcorr_acc.sv
module pcorr_acc #(
    parameter int N  = 31,
    parameter int SW = $clog2(N + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 chip_en,
    input  logic                 dump,
    input  logic                 ref_bit,
    input  logic                 rx_bit,
    output logic signed [SW-1:0] sum
);

    localparam logic signed [SW-1:0] LIM  = SW'(N);
    localparam logic                 NPAR = 1'(N % 2);

    typedef struct packed {
        logic [SW-1:0] acc;
        logic [SW-1:0] held;
    } acc_t;

    acc_t s_d, s_q;
    logic [SW-1:0] step;

    always_comb begin
        s_d  = s_q;
        step = (ref_bit == rx_bit) ? SW'(1) : '1;
        if (chip_en) begin
            if (dump) begin
                s_d.held = s_q.acc + step;
                s_d.acc  = '0;
            end else begin
                s_d.acc  = s_q.acc + step;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sum = $signed(s_q.held);

    // R3: a running sum never exceeds one period of chips in magnitude
    a_r3_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(s_q.acc) <= LIM) && ($signed(s_q.acc) >= -LIM));

    // R3: a dumped sum of exactly N unit terms has the parity of N
    a_r3_full_period: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_en && dump) |=> s_q.held[0] == NPAR);

endmodule

// File: rtl/pcorr_maxtree.sv
module pcorr_maxtree #(
    parameter int M  = 8,
    parameter int SW = 6,
    parameter int IW = (M > 1) ? $clog2(M) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [M-1:0]         in_mask,
    input  logic [M*SW-1:0]      in_val,
    output logic                 out_vld,
    output logic [IW-1:0]        out_idx,
    output logic signed [SW-1:0] out_val
);

    localparam int L  = (M > 1) ? $clog2(M) : 0;
    localparam int MP = 1 << L;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] val;
        logic [IW-1:0] idx;
    } cand_t;

    cand_t leaf [MP];

    always_comb begin
        for (int k = 0; k < MP; k++) begin
            if (k < M) begin
                leaf[k].vld = in_vld & in_mask[k];
                leaf[k].val = in_val[k*SW +: SW];
                leaf[k].idx = IW'(k);
            end else begin
                leaf[k] = '0;
            end
        end
    end

    generate
        if (L == 0) begin : g_flat
            assign out_vld = in_vld;
            assign out_idx = leaf[0].idx;
            assign out_val = $signed(leaf[0].val);
        end else begin : g_tree
            cand_t       nd_d [1:MP-1];
            cand_t       nd_q [1:MP-1];
            cand_t       view [1:2*MP-1];
            logic [L-1:0] vsr_d, vsr_q;

            always_comb begin
                for (int i = 1; i < MP; i++) view[i] = nd_q[i];
                for (int i = MP; i < 2 * MP; i++) view[i] = leaf[i - MP];
                for (int i = 1; i < MP; i++) begin
                    if (view[2*i+1].vld &&
                        (!view[2*i].vld ||
                         ($signed(view[2*i+1].val) > $signed(view[2*i].val))))
                        nd_d[i] = view[2*i+1];
                    else
                        nd_d[i] = view[2*i];
                end
                vsr_d = (vsr_q << 1) | L'(in_vld);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 1; i < MP; i++) nd_q[i] <= '0;
                    vsr_q <= '0;
                end else begin
                    for (int i = 1; i < MP; i++) nd_q[i] <= nd_d[i];
                    vsr_q <= vsr_d;
                end
            end

            assign out_vld = vsr_q[L-1];
            assign out_idx = nd_q[1].idx;
            assign out_val = $signed(nd_q[1].val);

            for (genvar gi = 1; gi < MP; gi++) begin : g_chk
                // R5: a node is never below a valid child of the previous cycle
                a_r5_node_max: assert property (@(posedge clk) disable iff (!rst_n)
                    nd_q[gi].vld |->
                        ((!$past(view[2*gi].vld) ||
                          $signed(nd_q[gi].val) >= $signed($past(view[2*gi].val))) &&
                         (!$past(view[2*gi+1].vld) ||
                          $signed(nd_q[gi].val) >= $signed($past(view[2*gi+1].val)))));
                // R5: on equal values the lower-index side is kept
                a_r5_tie_low: assert property (@(posedge clk) disable iff (!rst_n)
                    (nd_q[gi].vld && $past(view[2*gi].vld)) |->
                        (($signed(nd_q[gi].val) > $signed($past(view[2*gi].val))) ||
                         (nd_q[gi].idx == $past(view[2*gi].idx))));
            end
        end
    endgenerate

endmodule

// File: rtl/pcorr_bank.sv
module pcorr_bank
    import pcorr_pkg::*;
#(
    parameter int LFSR_W = 5,
    parameter int FB_TAP = 2,
    parameter int NCORR  = 8,
    parameter int N      = (1 << LFSR_W) - 1,
    parameter int PW     = $clog2(N),
    parameter int SW     = $clog2(N + 1) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 chip_valid,
    input  logic                 rx_chip,
    output logic                 busy,
    output logic                 res_valid,
    output logic [PW-1:0]        res_phase,
    output logic signed [SW-1:0] res_peak
);

    localparam int NGRP = (N + NCORR - 1) / NCORR;
    localparam int GW   = (NGRP > 1) ? $clog2(NGRP) : 1;
    localparam int CW   = $clog2(N);
    localparam int IW   = (NCORR > 1) ? $clog2(NCORR) : 1;

    typedef struct packed {
        srch_e            st;
        logic [CW-1:0]    cnt;
        logic [GW-1:0]    grp;
        logic [PW-1:0]    goff;
        logic             dump;
        logic [PW-1:0]    base;
        logic [NCORR-1:0] mask;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                  accept, last_chip, load;
    logic [N-1:0]          taps;
    logic [NCORR-1:0]      ref_bits;
    logic [NCORR-1:0]      act;
    logic [NCORR*SW-1:0]   sum_flat;
    logic                  t_vld;
    logic [IW-1:0]         t_idx;
    logic signed [SW-1:0]  t_val;

    // tap selection and window mask for the current group
    always_comb begin
        for (int k = 0; k < NCORR; k++) begin
            int t;
            t = int'(c_q.goff) + k;
            act[k] = (t < N);
            if (t >= N) t = t - N;
            ref_bits[k] = taps[t];
        end
    end

    always_comb begin
        c_d       = c_q;
        c_d.dump  = 1'b0;
        accept    = (c_q.st == S_RUN) && chip_valid;
        last_chip = accept && (c_q.cnt == CW'(N - 1));
        load      = (c_q.st == S_IDLE) && start;
        if (load) begin
            c_d.st   = S_RUN;
            c_d.cnt  = '0;
            c_d.grp  = '0;
            c_d.goff = '0;
        end else if (last_chip) begin
            c_d.dump = 1'b1;
            c_d.base = c_q.goff;
            c_d.mask = act;
            c_d.cnt  = '0;
            if (c_q.grp == GW'(NGRP - 1)) begin
                c_d.st   = S_IDLE;
                c_d.grp  = '0;
                c_d.goff = '0;
            end else begin
                c_d.grp  = c_q.grp + GW'(1);
                c_d.goff = c_q.goff + PW'(NCORR);
            end
        end else if (accept) begin
            c_d.cnt = c_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: S_IDLE, default: '0};
        else        c_q <= c_d;
    end

    pcorr_codegen #(.W(LFSR_W), .FB(FB_TAP), .N(N)) u_codegen (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (accept),
        .taps  (taps)
    );

    generate
        for (genvar gk = 0; gk < NCORR; gk++) begin : g_corr
            logic signed [SW-1:0] s_k;
            pcorr_acc #(.N(N), .SW(SW)) u_acc (
                .clk     (clk),
                .rst_n   (rst_n),
                .chip_en (accept),
                .dump    (last_chip),
                .ref_bit (ref_bits[gk]),
                .rx_bit  (rx_chip),
                .sum     (s_k)
            );
            assign sum_flat[gk*SW +: SW] = s_k;
        end
    endgenerate

    pcorr_maxtree #(.M(NCORR), .SW(SW), .IW(IW)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (c_q.dump),
        .in_mask (c_q.mask),
        .in_val  (sum_flat),
        .out_vld (t_vld),
        .out_idx (t_idx),
        .out_val (t_val)
    );

    assign busy      = (c_q.st == S_RUN);
    assign res_valid = t_vld;
    assign res_phase = c_q.base + PW'(t_idx);
    assign res_peak  = t_val;

    // R8: an accepted start raises busy on the next cycle
    a_r8_busy_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_IDLE && start) |=> busy);

    // R8 R4: the final period's last chip ends the search
    a_r4_search_end: assert property (@(posedge clk) disable iff (!rst_n)
        (last_chip && c_q.grp == GW'(NGRP - 1)) |=> !busy);

    // R7: a start during a search leaves the window unchanged
    a_r7_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !last_chip) |=> (busy && $stable(c_q.grp)));

    // R4: the window base stays inside the code
    a_r4_base_range: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.goff < PW'(N));

    // R6: one result pulse per period
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R4: a reported phase lies inside the code
    a_r4_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_phase < PW'(N));

endmodule

// File: tb/pcorr_bank_bench.sv
module pcorr_bank_lane #(
    parameter int W  = 5,
    parameter int FB = 2,
    parameter int M  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic chip_valid,
    input  logic rx_chip,
    output int   checks,
    output int   fails,
    output int   nres,
    output int   last_phase,
    output int   last_peak
);

    localparam int N  = (1 << W) - 1;
    localparam int PW = $clog2(N);
    localparam int SW = $clog2(N + 1) + 1;
    localparam int G  = (N + M - 1) / M;
    localparam int L  = (M > 1) ? $clog2(M) : 0;

    logic                 busy, res_valid;
    logic [PW-1:0]        res_phase;
    logic signed [SW-1:0] res_peak;

    pcorr_bank #(.LFSR_W(W), .FB_TAP(FB), .NCORR(M)) u_pcorr_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .chip_valid (chip_valid),
        .rx_chip    (rx_chip),
        .busy       (busy),
        .res_valid  (res_valid),
        .res_phase  (res_phase),
        .res_peak   (res_peak)
    );

    int code [N];
    int rxbuf [N];
    bit mbusy = 0;
    int mcnt = 0;
    int mgrp = 0;
    bit pv [L+1];
    int pp [L+1];
    int ps [L+1];

    initial begin
        for (int m = 0; m < N; m++)
            code[m] = (m < W) ? 1 : (code[m - W + FB] ^ code[m - W]);
        for (int j = 0; j <= L; j++) begin
            pv[j] = 0; pp[j] = 0; ps[j] = 0;
        end
        checks = 0; fails = 0; nres = 0; last_phase = -1; last_peak = 0;
    end

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            mbusy = 0; mcnt = 0; mgrp = 0;
            for (int j = 0; j <= L; j++) pv[j] = 0;
        end else begin
            for (int j = L; j > 0; j--) begin
                pv[j] = pv[j-1]; pp[j] = pp[j-1]; ps[j] = ps[j-1];
            end
            pv[0] = 0;
            if (mbusy && chip_valid) begin
                rxbuf[mcnt] = rx_chip;
                if (mcnt == N - 1) begin
                    int best_p, best_s;
                    best_p = -1; best_s = 0;
                    for (int k = 0; k < M; k++) begin
                        int p, s;
                        p = mgrp * M + k;
                        s = 0;
                        if (p < N) begin
                            for (int n = 0; n < N; n++)
                                s += (rxbuf[n] == code[(n - p + N) % N]) ? 1 : -1;
                            if (best_p < 0 || s > best_s) begin
                                best_p = p; best_s = s;
                            end
                        end
                    end
                    pv[0] = 1; pp[0] = best_p; ps[0] = best_s;
                    mcnt = 0;
                    mgrp++;
                    if (mgrp == G) begin
                        mbusy = 0; mgrp = 0;
                    end
                end else begin
                    mcnt++;
                end
            end else if (!mbusy && start) begin
                mbusy = 1; mcnt = 0; mgrp = 0;
            end
        end
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (!rst_n) begin
            checks++;
            if (busy !== 1'b0 || res_valid !== 1'b0) begin
                fails++;
                $display("FAIL R1 M=%0d reset: busy=%b valid=%b expected 0 0",
                         M, busy, res_valid);
            end
        end else begin
            checks++;
            if (busy !== mbusy) begin
                fails++;
                $display("FAIL R8 M=%0d busy=%b expected %b", M, busy, mbusy);
            end
            checks++;
            if (res_valid !== pv[L]) begin
                fails++;
                $display("FAIL R6 M=%0d res_valid=%b expected %b", M, res_valid, pv[L]);
            end
            if (pv[L] && res_valid === 1'b1) begin
                nres++;
                last_phase = int'(res_phase);
                last_peak  = int'(res_peak);
                checks++;
                if (int'(res_phase) != pp[L]) begin
                    fails++;
                    $display("FAIL R5 M=%0d res_phase=%0d expected %0d",
                             M, res_phase, pp[L]);
                end
                checks++;
                if (int'(res_peak) != ps[L]) begin
                    fails++;
                    $display("FAIL R2 R3 M=%0d res_peak=%0d expected %0d",
                             M, int'(res_peak), ps[L]);
                end
            end
        end
    end

endmodule

module pcorr_bank_bench;

    localparam int W  = 5;
    localparam int FB = 2;
    localparam int N  = (1 << W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic chip_valid = 1'b0;
    logic rx_chip = 1'b0;

    always #5 clk = ~clk;

    int chk8, bad8, res8, ph8, pk8;
    int chk31, bad31, res31, ph31, pk31;
    int tb_checks = 0;
    int tb_fails = 0;
    int cyc = 0;
    int code [N];

    pcorr_bank_lane #(.W(W), .FB(FB), .M(8)) u_lane8 (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_valid(chip_valid),
        .rx_chip(rx_chip), .checks(chk8), .fails(bad8), .nres(res8),
        .last_phase(ph8), .last_peak(pk8)
    );

    pcorr_bank_lane #(.W(W), .FB(FB), .M(31)) u_lane31 (
        .clk(clk), .rst_n(rst_n), .start(start), .chip_valid(chip_valid),
        .rx_chip(rx_chip), .checks(chk31), .fails(bad31), .nres(res31),
        .last_phase(ph31), .last_peak(pk31)
    );

    task automatic report_and_end();
        $display("== %0d vectors applied, %0d miscompares ==",
                 tb_checks + chk8 + chk31, tb_fails + bad8 + bad31);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tb_checks++;
        if (!ok) begin
            tb_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // kind 0: replica delayed by phase; 1: all ones; 2: random
    task automatic run_search(input int phase, input int gap, input int flips,
                              input int kind, input bit restart);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 4 * N; n++) begin
            int b;
            if (gap > 0 && (n % gap) == 0) begin
                chip_valid = 1'b0;
                rx_chip = ~rx_chip;
                @(negedge clk);
            end
            if (kind == 0)      b = code[((n % N) - phase + N) % N];
            else if (kind == 1) b = 1;
            else                b = int'($urandom_range(1, 0));
            if ((n % N) < flips) b = 1 - b;
            chip_valid = 1'b1;
            rx_chip = b[0];
            start = (restart && n == 10);  // R7: start while busy
            @(negedge clk);
            start = 1'b0;
        end
        chip_valid = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tb_fails++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            report_and_end();
        end
    end

    initial begin
        for (int m = 0; m < N; m++)
            code[m] = (m < W) ? 1 : (code[m - W + FB] ^ code[m - W]);
        void'($urandom(7));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R5: clean aligned replica at phase 13
        run_search(13, 0, 0, 0, 1'b0);
        check(ph31 == 13, "R5 wide bank phase", ph31, 13);
        check(pk31 == N, "R2 wide bank peak", pk31, N);
        check(ph8 == 24, "R5 narrow bank last window tie", ph8, 24);
        check(res8 == 4, "R4 narrow bank period count", res8, 4);
        check(res31 == 1, "R4 wide bank period count", res31, 1);

        // R3 R4 R7: last phase of final window, stalls, noise, restart pulse
        run_search(30, 3, 3, 0, 1'b1);
        check(ph8 == 30, "R4 final window phase", ph8, 30);
        check(pk8 == N - 6, "R3 stalled noisy peak", pk8, N - 6);
        check(ph31 == 30, "R5 wide bank phase", ph31, 30);
        check(res8 == 8, "R7 restart ignored count", res8, 8);

        // R7: chips offered while idle are ignored
        for (int n = 0; n < 20; n++) begin
            chip_valid = 1'b1;
            rx_chip = n[0];
            @(negedge clk);
        end
        chip_valid = 1'b0;
        @(negedge clk);
        check(res8 == 8 && res31 == 2, "R7 idle chips produce nothing", res8, 8);

        // R5: constant input makes every hypothesis tie at +1
        run_search(0, 0, 0, 1, 1'b0);
        check(ph31 == 0, "R5 tie lowest phase wide", ph31, 0);
        check(pk31 == 1, "R5 tie peak wide", pk31, 1);
        check(ph8 == 24, "R5 tie lowest phase narrow", ph8, 24);

        // random stream, reference model decides
        run_search(0, 2, 0, 2, 1'b0);
        check(res8 == 16, "R4 narrow bank total results", res8, 16);
        check(res31 == 4, "R4 wide bank total results", res31, 4);

        report_and_end();
    end

endmodule